// File: doc/BRIEF.md
# Lane-Mask-Aware Register Scoreboard

This block tracks destination registers that in-flight instructions of a SIMT core have not yet written back. Each pending write is held in a small associative table as a record of warp, register and the lanes that will write it. An issuing path asks whether a candidate instruction may go by presenting its warp, its destination or source registers and its lane mask. The block answers in the same cycle against all live records. Issue paths then reserve the candidate's non-zero destinations, and completion paths release them.

The block has two tracking modes, chosen by `mask_mode`. In lane-aware mode (`mask_mode`=1), two splits of one warp that write the same register on disjoint lanes hold separate records. A hazard exists only where lane masks overlap. In warp-granular mode (`mask_mode`=0), masks are ignored and a register is either pending for a warp or not. Records are then split between a primary table and a secondary table, selected per request by a select bit. Intra-warp split instructions use the secondary table. Reserving a register that is already pending in the same table for the same warp is refused and flagged. The mode is expected to change only while the table is empty.

Top module: `lmask_scoreboard`

## Requirements
- R1: With `mask_mode`=1, an accepted reservation stores one record of (warp, register, lane mask) for each non-zero register slot. A second reservation of the same warp and register with a disjoint mask is accepted and coexists with the first; `rsv_dup` stays 0.
- R2: With `mask_mode`=1, `qry_hazard` is 1 exactly when a live record has the query's warp, matches one of its non-zero register slots, and has a mask whose bitwise AND with `qry_mask` is non-zero. `qry_secondary` is ignored.
- R3: With `mask_mode`=0, `qry_hazard` is 1 when a live record has the query's warp, matches a non-zero register slot, and carries the same table select as `qry_secondary`. Lane masks play no part.
- R4: With `mask_mode`=0, a reservation in which any non-zero slot names a (warp, register) already live in the same table raises `rsv_dup` in that cycle, and nothing from the request is recorded.
- R5: With `mask_mode`=0, records of the secondary table (select 1) and of the primary table (select 0) never see each other in queries, reservations or releases.
- R6: A release removes every live record matching its warp and one of its non-zero register slots, and also its exact mask (`mask_mode`=1) or its table select (`mask_mode`=0). A release that matches nothing, or that repeats an earlier release, changes nothing.
- R7: A register slot holding 0 means no register: it reserves no record, produces no hazard and releases nothing.
- R8: Each request carries NDST=2 register slots, packed with slot d in bits [8d+7:8d]. Every non-zero slot of an accepted reservation takes its own record.
- R9: `rsv_full` is 1 in a reservation cycle when the non-zero slots outnumber the free records (16 records in all; free count taken before any same-cycle release). The request is then not recorded and must be held.
- R10: A reservation or release takes effect in queries from the next cycle on; a query in the same cycle sees the table as it was.
- R11: After reset the table is empty, and `qry_hazard`, `rsv_full` and `rsv_dup` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_mode | input | 1 | 1 = lane-aware tracking, 0 = warp-granular with two tables |
| rsv_valid | input | 1 | Reservation request |
| rsv_warp | input | 5 | Warp of the reservation |
| rsv_regs | input | 16 | Two destination register slots, 0 = none |
| rsv_mask | input | 32 | Lane mask of the reserving instruction |
| rsv_secondary | input | 1 | Table select in warp-granular mode |
| rsv_full | output | 1 | Not enough free records; request not taken |
| rsv_dup | output | 1 | Warp-granular duplicate; request not taken |
| qry_warp | input | 5 | Warp of the candidate |
| qry_regs | input | 16 | Two register slots of the candidate, 0 = none |
| qry_mask | input | 32 | Lane mask of the candidate |
| qry_secondary | input | 1 | Table select in warp-granular mode |
| qry_hazard | output | 1 | Candidate collides with a live record |
| rel_valid | input | 1 | Release request |
| rel_warp | input | 5 | Warp of the release |
| rel_regs | input | 16 | Two register slots to release, 0 = none |
| rel_mask | input | 32 | Exact mask of the records to release |
| rel_secondary | input | 1 | Table select in warp-granular mode |

## Verification
Directed sequences put disjoint, overlapping and nested lane masks on one warp and register. They tell lane-aware overlap apart from plain register matching, and exact-mask release apart from overlap release. The same sequences run in warp-granular mode with differing masks and both table selects. This separates mask-blind matching, the duplicate refusal and the isolation between the two tables. Fill-to-capacity patterns with one or two non-zero slots, some with a zero slot, locate the full threshold and the reg-0 exemption. Long random phases over a few warps and registers mix reserve, query and release in the same cycle and check the next-cycle visibility rule.

// File: rtl/lmsb_pkg.sv
package lmsb_pkg;
  parameter int NENT   = 16;
  parameter int WARP_W = 5;
  parameter int REG_W  = 8;
  parameter int LANES  = 32;
  parameter int NDST   = 2;
  localparam int REGS_W = NDST * REG_W;
  localparam int CNT_W  = $clog2(NENT + 1);

  typedef struct packed {
    logic              valid;
    logic              sec;
    logic [WARP_W-1:0] warp;
    logic [REG_W-1:0]  rg;
    logic [LANES-1:0]  mask;
  } sb_entry_t;

  function automatic logic [REG_W-1:0] slot_reg(input logic [REGS_W-1:0] regs, input int d);
    return regs[d*REG_W +: REG_W];
  endfunction

  function automatic logic lanes_meet(input logic [LANES-1:0] a, input logic [LANES-1:0] b);
    return |(a & b);
  endfunction

  function automatic logic [CNT_W-1:0] ones_n(input logic [NENT-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NENT; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/lmsb_match.sv
module lmsb_match
  import lmsb_pkg::*;
(
  input  sb_entry_t         ent,
  input  logic              mask_mode,
  input  logic [WARP_W-1:0] warp,
  input  logic [REG_W-1:0]  rg,
  input  logic [LANES-1:0]  mask,
  input  logic              sec,
  output logic              overlap_hit,
  output logic              exact_hit
);
  logic key_hit;
  assign key_hit     = ent.valid && (rg != '0) && (ent.warp == warp) && (ent.rg == rg);
  assign overlap_hit = key_hit && (mask_mode ? lanes_meet(ent.mask, mask) : (ent.sec == sec));
  assign exact_hit   = key_hit && (mask_mode ? (ent.mask == mask) : (ent.sec == sec));
endmodule

// File: rtl/lmsb_alloc.sv
module lmsb_alloc
  import lmsb_pkg::*;
(
  input  logic [NENT-1:0]            free_vec,
  input  logic [NDST-1:0]            need,
  output logic [NDST-1:0][NENT-1:0]  grant,
  output logic                       short_of
);
  logic [NENT-1:0] taken;

  always_comb begin
    taken = '0;
    for (int d = 0; d < NDST; d++) begin
      grant[d] = '0;
      if (need[d]) begin
        for (int i = 0; i < NENT; i++) begin
          if (free_vec[i] && !taken[i] && (grant[d] == '0)) grant[d][i] = 1'b1;
        end
      end
      taken = taken | grant[d];
    end
  end

  always_comb begin
    logic [CNT_W-1:0] want;
    want = '0;
    for (int d = 0; d < NDST; d++) want = want + CNT_W'(need[d]);
    short_of = (want > ones_n(free_vec));
  end
endmodule

// File: rtl/lmask_scoreboard.sv
module lmask_scoreboard
  import lmsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_mode,
  input  logic              rsv_valid,
  input  logic [4:0]        rsv_warp,
  input  logic [15:0]       rsv_regs,
  input  logic [31:0]       rsv_mask,
  input  logic              rsv_secondary,
  output logic              rsv_full,
  output logic              rsv_dup,
  input  logic [4:0]        qry_warp,
  input  logic [15:0]       qry_regs,
  input  logic [31:0]       qry_mask,
  input  logic              qry_secondary,
  output logic              qry_hazard,
  input  logic              rel_valid,
  input  logic [4:0]        rel_warp,
  input  logic [15:0]       rel_regs,
  input  logic [31:0]       rel_mask,
  input  logic              rel_secondary
);
  sb_entry_t                tbl [NENT];
  logic [NENT-1:0]          valid_vec;
  logic [NDST-1:0]          rsv_need;
  logic [NDST-1:0][NENT-1:0] q_hit, r_hit, d_hit, grant;
  logic [NDST-1:0][NENT-1:0] unused_exact_q, unused_exact_d, unused_ovl_r;
  logic [NENT-1:0]          rel_kill, grant_any;
  logic                     short_of, accept;
  logic [CNT_W-1:0]         need_cnt;

  always_comb begin
    for (int i = 0; i < NENT; i++) valid_vec[i] = tbl[i].valid;
  end

  always_comb begin
    need_cnt = '0;
    for (int d = 0; d < NDST; d++) begin
      rsv_need[d] = rsv_valid && (slot_reg(rsv_regs, d) != '0);
      need_cnt    = need_cnt + CNT_W'(rsv_need[d]);
    end
  end

  for (genvar d = 0; d < NDST; d++) begin : g_slot
    for (genvar i = 0; i < NENT; i++) begin : g_ent
      lmsb_match u_q (
        .ent(tbl[i]), .mask_mode(mask_mode), .warp(qry_warp),
        .rg(slot_reg(qry_regs, d)), .mask(qry_mask), .sec(qry_secondary),
        .overlap_hit(q_hit[d][i]), .exact_hit(unused_exact_q[d][i]));
      lmsb_match u_r (
        .ent(tbl[i]), .mask_mode(mask_mode), .warp(rel_warp),
        .rg(slot_reg(rel_regs, d)), .mask(rel_mask), .sec(rel_secondary),
        .overlap_hit(unused_ovl_r[d][i]), .exact_hit(r_hit[d][i]));
      lmsb_match u_d (
        .ent(tbl[i]), .mask_mode(1'b0), .warp(rsv_warp),
        .rg(slot_reg(rsv_regs, d)), .mask(rsv_mask), .sec(rsv_secondary),
        .overlap_hit(d_hit[d][i]), .exact_hit(unused_exact_d[d][i]));
    end
  end

  lmsb_alloc u_alloc (
    .free_vec(~valid_vec), .need(rsv_need), .grant(grant), .short_of(short_of));

  always_comb begin
    logic any_q, any_d;
    any_q = 1'b0;
    any_d = 1'b0;
    rel_kill  = '0;
    grant_any = '0;
    for (int d = 0; d < NDST; d++) begin
      any_q     = any_q | (|q_hit[d]);
      any_d     = any_d | (rsv_need[d] && (|d_hit[d]));
      rel_kill  = rel_kill | (r_hit[d] & {NENT{rel_valid}});
      grant_any = grant_any | grant[d];
    end
    qry_hazard = any_q;
    rsv_dup    = rsv_valid && !mask_mode && any_d;
    rsv_full   = rsv_valid && short_of;
  end

  assign accept = rsv_valid && !rsv_full && !rsv_dup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) tbl[i] <= '0;
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (rel_kill[i]) tbl[i].valid <= 1'b0;
        for (int d = 0; d < NDST; d++) begin
          if (accept && grant[d][i]) begin
            tbl[i] <= '{valid: 1'b1, sec: (mask_mode ? 1'b0 : rsv_secondary),
                        warp: rsv_warp, rg: slot_reg(rsv_regs, d), mask: rsv_mask};
          end
        end
      end
    end
  end

  // R11: reset empties the table
  assert_reset_empty_R11: assert property (@(posedge clk) !rst_n |=> (valid_vec == '0));
  // R9: a refused request for lack of room leaves the table untouched
  assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_full && !rel_valid) |=> $stable(valid_vec));
  // R9: the allocator only hands out records that are free
  assert_grant_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ((grant_any & valid_vec) == '0));
  // R4: a duplicate reservation records nothing
  assert_dup_rejects_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_dup && !rel_valid) |=> $stable(valid_vec));
  // R8: every non-zero slot of an accepted request occupies one record
  assert_slot_per_record_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !rel_valid) |=> ($countones(valid_vec) == $past($countones(valid_vec)) + $past(int'(need_cnt))));
  // R6: a release alone never adds records
  assert_release_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rsv_valid) |=> ($countones(valid_vec) <= $past($countones(valid_vec))));
endmodule

// File: tb/lmask_scoreboard_tb_top.sv
module lmask_scoreboard_tb_top;
  import lmsb_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mask_mode = 1'b1;
  logic rsv_valid = 0, rsv_secondary = 0, qry_secondary = 0, rel_valid = 0, rel_secondary = 0;
  logic [4:0]  rsv_warp = 0, qry_warp = 0, rel_warp = 0;
  logic [15:0] rsv_regs = 0, qry_regs = 0, rel_regs = 0;
  logic [31:0] rsv_mask = 0, qry_mask = 0, rel_mask = 0;
  logic rsv_full, rsv_dup, qry_hazard;

  always #10 clk = ~clk;

  lmask_scoreboard dut_i (.*);

  typedef struct {
    bit          sec;
    int unsigned warp;
    int unsigned rg;
    bit [31:0]   mask;
  } rec_t;
  rec_t model[$];

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 0;

  function automatic int unsigned rslot(input logic [15:0] v, input int d);
    return int'(v >> (8 * d)) & 255;
  endfunction

  function automatic bit exp_hazard();
    foreach (model[k])
      for (int d = 0; d < 2; d++) begin
        int unsigned r = rslot(qry_regs, d);
        if (r == 0 || model[k].rg != r || model[k].warp != qry_warp) continue;
        if (mask_mode ? ((model[k].mask & qry_mask) != 0) : (model[k].sec == qry_secondary)) return 1;
      end
    return 0;
  endfunction

  function automatic int want_slots();
    int n = 0;
    for (int d = 0; d < 2; d++) if (rslot(rsv_regs, d) != 0) n++;
    return n;
  endfunction

  function automatic bit exp_full();
    return rsv_valid && (want_slots() > 16 - model.size());
  endfunction

  function automatic bit exp_dup();
    if (!rsv_valid || mask_mode) return 0;
    foreach (model[k])
      for (int d = 0; d < 2; d++) begin
        int unsigned r = rslot(rsv_regs, d);
        if (r != 0 && model[k].rg == r && model[k].warp == rsv_warp && model[k].sec == rsv_secondary) return 1;
      end
    return 0;
  endfunction

  task automatic cmp(input string tag, input string what, input bit got, input bit exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s %s got=%0d expected=%0d at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  task automatic step(input string tag);
    bit ef, ed;
    rec_t keep[$];
    #1;
    ef = exp_full();
    ed = exp_dup();
    cmp(tag, "qry_hazard", qry_hazard, exp_hazard());
    cmp(tag, "rsv_full", rsv_full, ef);
    cmp(tag, "rsv_dup", rsv_dup, ed);
    @(posedge clk);
    if (rel_valid) begin
      foreach (model[k]) begin
        bit gone = 0;
        for (int d = 0; d < 2; d++) begin
          int unsigned r = rslot(rel_regs, d);
          if (r != 0 && model[k].rg == r && model[k].warp == rel_warp &&
              (mask_mode ? (model[k].mask == rel_mask) : (model[k].sec == rel_secondary))) gone = 1;
        end
        if (!gone) keep.push_back(model[k]);
      end
      model = keep;
    end
    if (rsv_valid && !ef && !ed)
      for (int d = 0; d < 2; d++)
        if (rslot(rsv_regs, d) != 0)
          model.push_back('{sec: mask_mode ? 1'b0 : rsv_secondary, warp: rsv_warp,
                            rg: rslot(rsv_regs, d), mask: rsv_mask});
    @(negedge clk);
  endtask

  task automatic idle();
    rsv_valid = 0; rel_valid = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    model.delete();
    rst_n = 1;
  endtask

  task automatic rsv(input int w, input int r0, input int r1, input logic [31:0] m, input bit s);
    rsv_valid = 1; rsv_warp = 5'(w); rsv_regs = {8'(r1), 8'(r0)}; rsv_mask = m; rsv_secondary = s;
  endtask
  task automatic qry(input int w, input int r0, input int r1, input logic [31:0] m, input bit s);
    qry_warp = 5'(w); qry_regs = {8'(r1), 8'(r0)}; qry_mask = m; qry_secondary = s;
  endtask
  task automatic rel(input int w, input int r0, input int r1, input logic [31:0] m, input bit s);
    rel_valid = 1; rel_warp = 5'(w); rel_regs = {8'(r1), 8'(r0)}; rel_mask = m; rel_secondary = s;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        misses++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
      end
    end
  end

  bit [31:0] masks [6] = '{32'h0000FFFF, 32'hFFFF0000, 32'h000000FF,
                           32'h00FF0000, 32'hFFFFFFFF, 32'h00000F00};

  initial begin
    @(negedge clk);
    do_reset();
    // R11: empty after reset
    mask_mode = 1; qry(3, 5, 6, 32'hFFFFFFFF, 0); step("R11");
    // R10: same-cycle query does not see the new record
    rsv(3, 5, 0, 32'h0000FFFF, 0); qry(3, 5, 0, 32'h0000FFFF, 0); step("R10");
    // R1/R2: disjoint split coexists, overlap query hits
    rsv(3, 5, 0, 32'hFFFF0000, 0); qry(3, 5, 0, 32'h000000F0, 0); step("R1");
    idle(); qry(3, 5, 0, 32'hFFFF0000, 1); step("R2");
    qry(3, 0, 5, 32'h00010000, 0); step("R2");
    qry(4, 5, 0, 32'hFFFFFFFF, 0); step("R2");
    qry(3, 6, 0, 32'hFFFFFFFF, 0); step("R2");
    // R6: release with non-exact mask does nothing
    rel(3, 5, 0, 32'h000000FF, 0); qry(3, 5, 0, 32'h000000F0, 0); step("R6");
    idle(); step("R6");
    rel(3, 5, 0, 32'h0000FFFF, 0); step("R6");
    idle(); step("R6");
    qry(3, 5, 0, 32'hFFFF0000, 0); step("R6");
    rel(3, 5, 0, 32'h0000FFFF, 0); step("R6");
    // R7: zero slots
    idle(); rsv(7, 0, 0, 32'hFFFFFFFF, 0); qry(7, 0, 0, 32'hFFFFFFFF, 0); step("R7");
    idle(); step("R7");
    // R8/R9: fill to capacity
    for (int k = 0; k < 7; k++) begin rsv(9, 10 + 2 * k, 11 + 2 * k, 32'h1, 0); step("R8"); end
    idle(); qry(9, 23, 0, 32'h1, 0); step("R8");
    rsv(10, 1, 2, 32'h1, 0); step("R9");
    rsv(10, 1, 0, 32'h1, 0); step("R9");
    rsv(10, 0, 3, 32'h1, 0); step("R9");
    rsv(10, 1, 2, 32'h1, 0); rel(9, 10, 0, 32'h1, 0); step("R9");
    idle(); rsv(10, 1, 2, 32'h1, 0); step("R9");
    idle(); qry(10, 1, 2, 32'h1, 0); step("R9");

    // warp-granular mode
    do_reset();
    mask_mode = 0;
    rsv(1, 9, 0, 32'h1, 0); qry(1, 9, 0, 32'h2, 0); step("R10");
    idle(); step("R3");
    qry(1, 9, 0, 32'h2, 1); step("R5");
    rsv(1, 9, 0, 32'h4, 0); step("R4");
    rsv(1, 0, 9, 32'h4, 1); step("R5");
    idle(); qry(1, 9, 0, 32'h0, 1); step("R5");
    rel(1, 9, 0, 32'hFFFFFFFF, 0); step("R6");
    idle(); qry(1, 9, 0, 32'h0, 0); step("R6");
    qry(1, 9, 0, 32'h0, 1); step("R5");

    // random mixes in each mode
    for (int ph = 0; ph < 2; ph++) begin
      do_reset();
      mask_mode = (ph == 0);
      for (int n = 0; n < 3000; n++) begin
        rsv_valid = ($urandom_range(0, 2) != 0);
        rel_valid = ($urandom_range(0, 2) == 0);
        rsv_warp = 5'($urandom_range(0, 3)); qry_warp = 5'($urandom_range(0, 3));
        rel_warp = 5'($urandom_range(0, 3));
        rsv_regs = {8'($urandom_range(0, 5)), 8'($urandom_range(0, 5))};
        qry_regs = {8'($urandom_range(0, 5)), 8'($urandom_range(0, 5))};
        rel_regs = {8'($urandom_range(0, 5)), 8'($urandom_range(0, 5))};
        rsv_mask = masks[$urandom_range(0, 5)]; qry_mask = masks[$urandom_range(0, 5)];
        rel_mask = masks[$urandom_range(0, 5)];
        rsv_secondary = 1'($urandom_range(0, 1)); qry_secondary = 1'($urandom_range(0, 1));
        rel_secondary = 1'($urandom_range(0, 1));
        step(ph == 0 ? "R2" : "R3");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule